// File: doc/BRIEF.md
# L2 Sharer Directory for Write-Through L1 Data Caches

This block sits beside one shared L2 bank. For every L2 line that it models, it keeps a presence vector with one bit for each core's private L1 data cache. Cores send it three kinds of request over a valid/ready channel:

- a load miss, which fills the line into the requester's L1;
- a write-through store, which does not allocate in the storing L1;
- an L2 eviction.

Because every L1 writes through to the L2, the directory never has to fetch data back from an L1. The only message it issues is an invalidation. That message is a core mask together with the line index, presented on a second valid/ready channel.

A load adds the requester to the line's sharer set. A store invalidates every sharer except the storing core and clears their bits. A storing core that already held the line keeps its bit, because it updates its own copy in place. An eviction invalidates every sharer, which keeps the L2 a superset of all the L1s. While a pending invalidation is refused downstream, the directory accepts no new request.

Top module: `dir_sharer_top`

## Requirements
- R1: After reset every entry has an empty sharer set, `invValid` is low and `reqReady` is high.
- R2: An accepted load (`reqOp` = 0) sets the requesting core's bit in the entry for `reqLine` and produces no invalidation.
- R3: An accepted store (`reqOp` = 1) on a line with sharers other than the requester raises `invValid` in the cycle after acceptance. `invMask` then holds exactly those other sharers (bit i means core i) and `invLine` holds the request's line. Those bits are cleared in the entry.
- R4: A store keeps the storing core's bit if it was set and never sets it if it was clear.
- R5: An accepted eviction (`reqOp` = 2) empties the entry. If the entry had sharers, it issues one invalidation whose mask is the whole former sharer set. If it had none, it issues nothing.
- R6: A store whose only sharer is the storing core, or whose line has no sharers, issues no invalidation.
- R7: While `invValid` is high and `invReady` is low, `invMask` and `invLine` stay unchanged, `reqReady` is low and no request is taken.
- R8: Operation code 3 is accepted but changes no entry and issues no invalidation.
- R9: Each line index has its own entry, and a request to one line never alters another line's entry.
- R10: A request accepted in the cycle right after another request to the same line acts on the state that the first request left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be taken this cycle |
| reqOp | input | 2 | 0 load miss, 1 store, 2 evict, 3 no-op |
| reqCore | input | 3 | Requesting core |
| reqLine | input | 6 | Line index |
| invValid | output | 1 | Invalidation pending |
| invReady | input | 1 | Downstream takes the invalidation |
| invMask | output | 8 | Cores to invalidate |
| invLine | output | 6 | Line to invalidate |

## Verification
Two events can fall in the same clock edge. The downstream side can consume the pending invalidation while a new request is being accepted, and that new request may itself produce the next invalidation. The bench provokes this by holding `invReady` high while it issues stores and evictions back to back, and again in a random phase where `invReady` and `reqValid` toggle independently. A behavioural reference model is compared with the design every cycle. It checks that the old message is retired, that the new one replaces it with the correct mask, and that a request issued on a zero-mask edge leaves `invValid` low.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_EVICT = 2'd2,
    OP_NONE  = 2'd3
  } dirOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic invLoad;
    logic invClear;
  } dirStrobeS;
endpackage

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      invReady,
  input  logic      maskNonZero,
  output logic      reqReady,
  output logic      invValid,
  output dirStrobeS strobes
);
  // a held invalidation blocks intake (R7)
  assign reqReady = !(invValid && !invReady);

  always_comb begin
    strobes.accept   = reqValid && reqReady;
    strobes.invLoad  = strobes.accept && maskNonZero;
    strobes.invClear = invValid && invReady && !strobes.invLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 invValid <= 1'b0;
    else if (strobes.invLoad)  invValid <= 1'b1;
    else if (strobes.invClear) invValid <= 1'b0;
  end
endmodule

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int LINE_AW   = 6,
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int DEPTH    = 1 << LINE_AW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dirStrobeS            strobes,
  input  logic [1:0]           reqOp,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [LINE_AW-1:0]   reqLine,
  output logic                 maskNonZero,
  output logic [NUM_CORES-1:0] invMask,
  output logic [LINE_AW-1:0]   invLine
);
  logic [NUM_CORES-1:0] rows [DEPTH];
  logic [NUM_CORES-1:0] curSharers;
  logic [NUM_CORES-1:0] nextSharers;
  logic [NUM_CORES-1:0] sendMask;
  logic [NUM_CORES-1:0] coreBit;

  // one presence vector per line (R9)
  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [NUM_CORES-1:0] row;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) row <= '0;
      else if (strobes.accept && reqLine == LINE_AW'(g)) row <= nextSharers;
    end
    assign rows[g] = row;
  end

  assign curSharers = rows[reqLine];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bit
    assign coreBit[c] = (reqCore == CORE_W'(c));
  end

  always_comb begin
    nextSharers = curSharers;
    sendMask    = '0;
    unique case (dirOpE'(reqOp))
      OP_LOAD:  nextSharers = curSharers | coreBit;
      OP_STORE: begin
        sendMask    = curSharers & ~coreBit;
        nextSharers = curSharers & coreBit;
      end
      OP_EVICT: begin
        sendMask    = curSharers;
        nextSharers = '0;
      end
      default: ;
    endcase
  end

  assign maskNonZero = |sendMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invMask <= '0;
      invLine <= '0;
    end else if (strobes.invLoad) begin
      invMask <= sendMask;
      invLine <= reqLine;
    end
  end
endmodule

// File: rtl/dir_sharer_top.sv
module dir_sharer_top
  import dir_pkg::*;
#(
  parameter int NUM_CORES = 8,
  parameter int LINE_AW   = 6,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic [1:0]           reqOp,
  input  logic [CORE_W-1:0]    reqCore,
  input  logic [LINE_AW-1:0]   reqLine,
  output logic                 invValid,
  input  logic                 invReady,
  output logic [NUM_CORES-1:0] invMask,
  output logic [LINE_AW-1:0]   invLine
);
  dirStrobeS strobes;
  logic      maskNonZero;

  dir_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .invReady(invReady),
    .maskNonZero(maskNonZero), .reqReady(reqReady), .invValid(invValid),
    .strobes(strobes)
  );

  dir_datapath #(.NUM_CORES(NUM_CORES), .LINE_AW(LINE_AW)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqOp(reqOp),
    .reqCore(reqCore), .reqLine(reqLine), .maskNonZero(maskNonZero),
    .invMask(invMask), .invLine(invLine)
  );
endmodule

// File: rtl/dir_checker.sv
module dir_checker #(
  parameter int NUM_CORES = 8,
  parameter int LINE_AW   = 6,
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [1:0]           reqOp,
  input logic [CORE_W-1:0]    reqCore,
  input logic [LINE_AW-1:0]   reqLine,
  input logic                 invValid,
  input logic                 invReady,
  input logic [NUM_CORES-1:0] invMask,
  input logic [LINE_AW-1:0]   invLine
);
  logic taken;
  assign taken = reqValid && reqReady;

  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invReady) |-> !reqReady);

  p_inv_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invReady) |=> (invValid && $stable(invMask) && $stable(invLine)));

  p_mask_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (|invMask));

  p_load_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqOp == 2'd0) |=> !invValid);

  p_store_skips_self_r4: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqOp == 2'd1) |=> (!invValid || !invMask[$past(reqCore)]));

  p_nop_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqOp == 2'd3) |=> !invValid);

  p_line_tag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (taken && reqOp != 2'd0) |=> (!invValid || invLine == $past(reqLine)));
endmodule

bind dir_sharer_top dir_checker #(.NUM_CORES(NUM_CORES), .LINE_AW(LINE_AW)) i_chk (.*);

// File: tb/test_dir_sharer_top.sv
`timescale 1ns/1ps
module test_dir_sharer_top;
  localparam int NC = 8;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [2:0] reqCore = '0;
  logic [AW-1:0] reqLine = '0;
  logic invReady = 1'b1;
  logic reqReady, invValid;
  logic [NC-1:0] invMask;
  logic [AW-1:0] invLine;

  int checks = 0;
  int fails = 0;
  string curReq = "R1";

  // reference model state
  int dirM [64];
  bit eV = 0;
  int eM = 0;
  int eL = 0;
  bit lastAccept = 0;

  always #4 clk = ~clk;

  dir_sharer_top i_dir_sharer_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqCore(reqCore), .reqLine(reqLine),
    .invValid(invValid), .invReady(invReady), .invMask(invMask), .invLine(invLine)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (dirM[i]) dirM[i] = 0;
      eV = 0; lastAccept = 0;
    end else begin
      bit rdy;
      bit acc;
      int cur, bitv, m;
      rdy = !(eV && !invReady);
      acc = reqValid && rdy;
      if (eV && invReady) eV = 0;
      if (acc) begin
        cur = dirM[reqLine];
        bitv = 1 << reqCore;
        m = 0;
        case (reqOp)
          2'd0: dirM[reqLine] = cur | bitv;
          2'd1: begin m = cur & ~bitv; dirM[reqLine] = cur & bitv; end
          2'd2: begin m = cur; dirM[reqLine] = 0; end
          default: ;
        endcase
        if (m != 0) begin eV = 1; eM = m; eL = reqLine; end
      end
      lastAccept = acc;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  // compare every cycle, after inputs settle
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      chk("reqReady", int'(reqReady), int'(!(eV && !invReady)));
      chk("invValid", int'(invValid), int'(eV));
      if (eV) begin
        chk("invMask", int'(invMask), eM);
        chk("invLine", int'(invLine), eL);
      end
    end
  end

  task automatic issue(input int op, input int core, input int line);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'(op); reqCore = 3'(core); reqLine = AW'(line);
    do begin @(posedge clk); #1; end while (!lastAccept);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state; evict of empty line yields nothing
    curReq = "R1";
    idle(2);
    chk("reset ready", int'(reqReady), 1);
    issue(2, 0, 5); idle(2);
    // R2: loads add sharers silently
    curReq = "R2";
    issue(0, 1, 10); issue(0, 3, 10); issue(0, 5, 10); idle(2);
    // R3: store from a sharer invalidates the others
    curReq = "R3";
    issue(1, 1, 10); idle(2);
    // R4: storing sharer kept; eviction shows only core 1
    curReq = "R4";
    issue(2, 0, 10); idle(2);
    issue(0, 0, 11); issue(1, 2, 11); idle(1); issue(2, 0, 11); idle(2);
    // R5: eviction of several sharers
    curReq = "R5";
    issue(0, 6, 30); issue(0, 7, 30); issue(2, 3, 30); idle(2);
    // R6: lone sharer stores silently
    curReq = "R6";
    issue(0, 4, 12); issue(1, 4, 12); issue(1, 2, 13); idle(2);
    // R7: stalled invalidation holds and blocks intake
    curReq = "R7";
    for (int c = 0; c < NC; c++) issue(0, c, 20);
    @(negedge clk); invReady = 1'b0;
    issue(1, 7, 20);
    @(negedge clk); reqValid = 1'b1; reqOp = 2'd2; reqLine = AW'(21);
    repeat (4) @(negedge clk);
    invReady = 1'b1;
    do begin @(posedge clk); #1; end while (!lastAccept);
    idle(2);
    // R8: no-op leaves entry untouched
    curReq = "R8";
    issue(0, 2, 40); issue(3, 5, 40); idle(1); issue(2, 0, 40); idle(2);
    // R9: lines at both ends are independent
    curReq = "R9";
    issue(0, 1, 0); issue(0, 2, 63); issue(2, 0, 0); issue(2, 0, 63); idle(2);
    // R10: back to back on one line, with same-edge drain
    curReq = "R10";
    issue(0, 2, 50); issue(0, 3, 50); issue(1, 6, 50); issue(0, 6, 50);
    issue(0, 1, 50); issue(1, 1, 50); issue(2, 0, 50); idle(2);
    // random mix, including simultaneous drain and accept
    curReq = "R3";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      invReady = ($urandom % 4) != 0;
      reqValid = ($urandom % 3) != 0;
      reqOp = 2'($urandom);
      reqCore = 3'($urandom);
      reqLine = AW'($urandom % 6);
    end
    @(negedge clk); reqValid = 1'b0; invReady = 1'b1;
    idle(4);
    finishRun();
  end
endmodule